// File: doc/BRIEF.md
# Asynchronous Serial Receiver Front End

This block recovers characters from an asynchronous serial line. A one-cycle enable at sixteen times the bit rate paces all sampling. A falling edge on the idle-high line arms the receiver. The start bit is confirmed at its middle, and every following bit is taken at its centre. Each finished character is handed to an external receive queue through a single-cycle push, together with three error tags: parity, framing and break.

Configuration inputs set the character length (5 to 8 data bits), the parity mode and whether one or two stop bits make up the character frame.

After a framing error, the receiver assumes the low stop sample was really the next start bit. It carries straight on into that character's data bits.

A line held low for longer than a whole character frame produces a single all-zero break character. After that, nothing more is received until the line has been high for half a bit time. When the queue reports full, a character is dropped and an overrun pulse is raised instead.

Top module: `serial_rx_frontend`

## Requirements
- R1: While reset is asserted and after its release with the line idle high, `push_o` and `overrun_o` stay low.
- R2: A start bit is accepted only if the line is still low 8 oversample ticks after the falling edge. A shorter low pulse produces no push.
- R3: Data bits are taken least significant first. `cfg_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits of `push_data_o` above the chosen length read zero.
- R4: `cfg_par_i` selects the parity mode: 0 none, 1 odd, 2 even, 3 parity bit always one, 4 parity bit always zero. When the received parity bit differs from the expected one, tag bit 0 is set.
- R5: When the first stop bit is sampled low, tag bit 1 (framing) is set. `cfg_stop2_i` only lengthens the frame used for break timing.
- R6: After a framing error on a character that was not all zero, the low stop sample is taken as the start of the next character. Its first data bit is sampled 16 ticks later.
- R7: A line that stays low for longer than a full frame (start, data, parity and stop bits) produces exactly one push, with data 0 and tag 3'b110 (break plus framing).
- R8: After a break, no character is received until the line has been high for 8 consecutive ticks.
- R9: An all-zero frame whose low stop ends before the break time is pushed with data 0 and the framing tag. The receiver then returns to idle without resynchronising.
- R10: When `full_i` is high as a character completes, `push_o` stays low and `overrun_o` pulses for one cycle.
- R11: Each character produces at most one single-cycle push, with the tags of that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversample enable, 16 per bit |
| rx_i | input | 1 | Asynchronous serial line |
| cfg_len_i | input | 2 | Data length code (5 + value bits) |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_stop2_i | input | 1 | Two stop bits in the frame |
| full_i | input | 1 | Receive queue full |
| push_o | output | 1 | Character push strobe |
| push_data_o | output | 8 | Received data |
| push_tag_o | output | 3 | Tags: bit2 break, bit1 framing, bit0 parity |
| overrun_o | output | 1 | Character dropped, queue full |

## Verification
Random frames vary the length, parity mode, stop count and data. A random fraction of them carry a corrupted parity bit. Together these separate a correct bit order, length mask and parity polarity from wrong ones.

Several directed line patterns cover the rest:
- A framing error followed by a second character tells a resynchronising receiver from one that waits for the next falling edge.
- A short low glitch checks that the start bit is validated at its middle.
- An all-zero frame with a low stop that ends early is kept apart from a line held low well past a frame, which must give exactly one break character.
- Low pulses shorter than half a bit after a break show that the receiver re-arms only after the required high time.
- Holding the queue full shows that a character is dropped and the overrun pulse is raised.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_ZERO = 3'd4
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_PEND, S_BRK
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/srx_parity.sv
`timescale 1ns/1ps
module srx_parity
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,  // upper bits already zero
  input  logic [2:0]        mode_i,
  output logic              en_o,
  output logic              expect_o
);
  always_comb begin
    en_o     = 1'b1;
    expect_o = 1'b0;
    unique case (par_mode_e'(mode_i))
      PAR_ODD:  expect_o = ~^data_i;
      PAR_EVEN: expect_o = ^data_i;
      PAR_ONE:  expect_o = 1'b1;
      PAR_ZERO: expect_o = 1'b0;
      default:  en_o     = 1'b0;
    endcase
  end
endmodule

// File: rtl/srx_low_timer.sv
`timescale 1ns/1ps
module srx_low_timer #(
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic [RUN_W-1:0] limit_i,
  output logic             over_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (tick_i) begin
      if (rx_i)              run_q <= '0;
      else if (run_q != '1)  run_q <= run_q + 1'b1;
    end
  end

  assign over_o = run_q > limit_i;
endmodule

// File: rtl/serial_rx_frontend.sv
`timescale 1ns/1ps
module serial_rx_frontend
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [2:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic [2:0]        push_tag_o,
  output logic              overrun_o
);
  localparam int CNT_W     = $clog2(OVS);
  localparam int HALF      = OVS / 2;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int MIN_BITS  = DATA_W - 3;
  localparam int MAX_FRAME = DATA_W + 4;
  localparam int RUN_W     = $clog2(MAX_FRAME * OVS + 2);
  localparam int BITS_W    = $clog2(MAX_FRAME + 1);

  logic rx_s;
  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pbit_q, pbit_d;

  logic              par_en, par_exp, par_err, brk_over;
  logic [BITS_W-1:0] nbits, frame_bits;
  logic [RUN_W-1:0]  brk_limit;

  assign nbits      = BITS_W'(MIN_BITS) + BITS_W'(cfg_len_i);
  assign frame_bits = nbits + BITS_W'(1) + BITS_W'(par_en) + (cfg_stop2_i ? BITS_W'(2) : BITS_W'(1));
  assign brk_limit  = RUN_W'(frame_bits) * RUN_W'(OVS);

  srx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i(data_q), .mode_i(cfg_par_i), .en_o(par_en), .expect_o(par_exp)
  );
  assign par_err = par_en && (pbit_q != par_exp);

  srx_low_timer #(.RUN_W(RUN_W)) u_low (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .rx_i(rx_s),
    .limit_i(brk_limit), .over_o(brk_over)
  );

  logic              emit;
  rx_tag_t           emit_tag;
  logic [DATA_W-1:0] emit_data;
  logic              bit_end;

  assign bit_end = (cnt_q == CNT_W'(OVS - 1));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    data_d    = data_q;
    pbit_d    = pbit_q;
    emit      = 1'b0;
    emit_tag  = '0;
    emit_data = data_q;
    if (tick16_i) begin
      unique case (state_q)
        S_IDLE: if (!rx_s) begin
          state_d = S_START;
          cnt_d   = '0;
        end
        S_START: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_d   = '0;
            idx_d   = '0;
            data_d  = '0;
            state_d = rx_s ? S_IDLE : S_DATA;  // high at mid-bit: glitch
          end
        end
        S_DATA: begin
          cnt_d = cnt_q + 1'b1;
          if (bit_end) begin
            cnt_d         = '0;
            data_d[idx_q] = rx_s;
            idx_d         = idx_q + 1'b1;
            if (idx_q == IDX_W'(nbits - 1'b1)) state_d = par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt_d = cnt_q + 1'b1;
          if (bit_end) begin
            cnt_d   = '0;
            pbit_d  = rx_s;
            state_d = S_STOP;
          end
        end
        S_STOP: begin
          cnt_d = cnt_q + 1'b1;
          if (bit_end) begin
            cnt_d = '0;
            if (rx_s) begin
              emit     = 1'b1;
              emit_tag = '{brk: 1'b0, frm: 1'b0, par: par_err};
              state_d  = S_IDLE;
            end else if (data_q == '0 && !(par_en && pbit_q)) begin
              state_d = S_PEND;  // break candidate: hold the push
            end else begin
              // low stop taken as next start bit
              emit     = 1'b1;
              emit_tag = '{brk: 1'b0, frm: 1'b1, par: par_err};
              idx_d    = '0;
              data_d   = '0;
              state_d  = S_DATA;
            end
          end
        end
        S_PEND: begin
          if (rx_s) begin
            emit     = 1'b1;
            emit_tag = '{brk: 1'b0, frm: 1'b1, par: par_err};
            state_d  = S_IDLE;
          end else if (brk_over) begin
            emit      = 1'b1;
            emit_tag  = '{brk: 1'b1, frm: 1'b1, par: 1'b0};
            emit_data = '0;
            cnt_d     = '0;
            state_d   = S_BRK;
          end
        end
        S_BRK: begin
          if (!rx_s) cnt_d = '0;
          else if (cnt_q == CNT_W'(HALF - 1)) state_d = S_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      data_q      <= '0;
      pbit_q      <= 1'b0;
      push_o      <= 1'b0;
      overrun_o   <= 1'b0;
      push_data_o <= '0;
      push_tag_o  <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      data_q    <= data_d;
      pbit_q    <= pbit_d;
      push_o    <= emit && !full_i;
      overrun_o <= emit && full_i;
      if (emit && !full_i) begin
        push_data_o <= emit_data;
        push_tag_o  <= emit_tag;
      end
    end
  end
endmodule

// File: rtl/srx_checker.sv
`timescale 1ns/1ps
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_i,
  input logic [1:0]        cfg_len_i,
  input logic              push_o,
  input logic [DATA_W-1:0] push_data_o,
  input logic [2:0]        push_tag_o,
  input logic              overrun_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!push_o && !overrun_o); // R1
  end

  AST_PUSH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(full_i)); // R10
  AST_OVR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o); // R10
  AST_OVR_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> !push_o); // R10
  AST_PUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o); // R11
  AST_BRK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_tag_o[2]) |-> (push_data_o == '0 && push_tag_o == 3'b110)); // R7
  AST_LEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ((push_data_o >> (DATA_W - 3 + int'(cfg_len_i))) == '0)); // R3
endmodule

bind serial_rx_frontend srx_checker #(.DATA_W(DATA_W)) u_srx_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_i(full_i), .cfg_len_i(cfg_len_i),
  .push_o(push_o), .push_data_o(push_data_o), .push_tag_o(push_tag_o),
  .overrun_o(overrun_o)
);

// File: tb/tb_serial_rx_frontend.sv
`timescale 1ns/1ps
module tb_serial_rx_frontend;
  localparam int DIV = 4;  // clocks per oversample tick

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1, full = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic       cfg_stop2 = 1'b0;
  logic       push, ovr;
  logic [7:0] pdata;
  logic [2:0] ptag;

  int checks = 0, errors = 0, div = 0;
  int wr = 0, rd = 0, ovr_cnt = 0;
  bit done = 0;
  logic [7:0] q_data [0:255];
  logic [2:0] q_tag  [0:255];

  serial_rx_frontend dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx),
    .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_stop2_i(cfg_stop2),
    .full_i(full), .push_o(push), .push_data_o(pdata), .push_tag_o(ptag),
    .overrun_o(ovr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == DIV - 1) ? 0 : div + 1;
    tick <= (div == DIV - 1);
  end

  always @(negedge clk) if (rst_n) begin
    if (push) begin
      q_data[wr[7:0]] = pdata;
      q_tag[wr[7:0]]  = ptag;
      wr++;
    end
    if (ovr) ovr_cnt++;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int ticks);
    rx = v;
    repeat (ticks * DIV) @(negedge clk);
  endtask

  function automatic logic [7:0] mask(input logic [7:0] d, input logic [1:0] len);
    return d & 8'((9'd1 << (5 + len)) - 1);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [2:0] mode);
    case (mode)
      3'd1:    return ~^d;
      3'd2:    return ^d;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // start, data LSB first, optional parity, first stop; second stop high if enabled
  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v);
    logic [7:0] m;
    m = mask(d, cfg_len);
    hold(1'b0, 16);
    for (int i = 0; i < 5 + int'(cfg_len); i++) hold(m[i], 16);
    if (cfg_par != 3'd0) hold(exp_par(m, cfg_par) ^ bad_par, 16);
    hold(stop_v, 16);
    if (cfg_stop2 && stop_v) hold(1'b1, 16);
  endtask

  task automatic expect_push(input string req, input logic [7:0] d, input logic [2:0] t);
    if (rd >= wr) check({req, " missing push"}, 1'b0, wr - rd, 1);
    else begin
      check({req, " data"}, q_data[rd[7:0]] == d, int'(q_data[rd[7:0]]), int'(d));
      check({req, " tag"},  q_tag[rd[7:0]] == t,  int'(q_tag[rd[7:0]]),  int'(t));
      rd++;
    end
  endtask

  task automatic expect_none(input string req);
    check({req, " extra pushes"}, wr == rd, wr - rd, 0);
    rd = wr;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (10) @(negedge clk);
    check("R1 push low in reset", push == 1'b0, push, 0);
    rst_n = 1'b1;
    hold(1'b1, 40);
    check("R1 no push after reset", wr == 0 && !push, wr, 0);
    check("R1 no overrun after reset", ovr_cnt == 0, ovr_cnt, 0);

    // R3 R4: random frames across length, parity mode and stop count
    for (int n = 0; n < 60; n++) begin
      logic [7:0] d;
      logic bad;
      cfg_len   = 2'($urandom_range(0, 3));
      cfg_par   = 3'($urandom_range(0, 4));
      cfg_stop2 = 1'($urandom_range(0, 1));
      d   = 8'($urandom);
      bad = (cfg_par != 3'd0) && ($urandom_range(0, 4) == 0);
      hold(1'b1, 4);
      send(d, bad, 1'b1);
      hold(1'b1, 32);
      expect_push(bad ? "R4 parity error" : "R3 R4 good frame", mask(d, cfg_len), {2'b00, bad});
      expect_none("R11 one push per frame");
    end

    // R3 fixed pattern, 5 bits, LSB first
    cfg_len = 2'd0; cfg_par = 3'd0; cfg_stop2 = 1'b0;
    send(8'hF3, 1'b0, 1'b1);
    hold(1'b1, 32);
    expect_push("R3 five-bit mask", 8'h13, 3'b000);

    // R2: short low glitch
    cfg_len = 2'd3;
    hold(1'b0, 4);
    hold(1'b1, 40);
    expect_none("R2 glitch ignored");

    // R5 R6: framing error, stop low taken as next start
    send(8'hA5, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) hold(8'h3C >> i, 16);
    hold(1'b1, 40);
    expect_push("R5 framing tag", 8'hA5, 3'b010);
    expect_push("R6 resynced char", 8'h3C, 3'b000);
    expect_none("R6 no extra");

    // R9: all-zero frame, low stop ending before break time
    cfg_par = 3'd2; cfg_stop2 = 1'b1;
    send(8'h00, 1'b0, 1'b0);
    hold(1'b1, 40);
    expect_push("R9 zero frame framing only", 8'h00, 3'b010);
    expect_none("R9 no resync char");

    // R7: long break gives one char
    cfg_par = 3'd0; cfg_stop2 = 1'b0;
    hold(1'b0, 400);
    hold(1'b1, 4);
    expect_push("R7 break char", 8'h00, 3'b110);
    expect_none("R7 single break push");

    // R8: short highs after break do not re-arm
    hold(1'b0, 20);
    hold(1'b1, 5);
    hold(1'b0, 20);
    expect_none("R8 no rx before re-arm");
    hold(1'b1, 16);
    send(8'h5A, 1'b0, 1'b1);
    hold(1'b1, 32);
    expect_push("R8 rx after re-arm", 8'h5A, 3'b000);
    expect_none("R8 no extra");

    // R10: overrun
    full = 1'b1;
    send(8'h77, 1'b0, 1'b1);
    hold(1'b1, 32);
    full = 1'b0;
    check("R10 overrun pulse count", ovr_cnt == 1, ovr_cnt, 1);
    expect_none("R10 dropped char");
    send(8'h81, 1'b0, 1'b1);
    hold(1'b1, 32);
    expect_push("R10 recovery", 8'h81, 3'b000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end
endmodule